// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Reads and Buffered Writes

This block keeps wall-clock time and date as eight BCD bytes: seconds, minutes, hours, date, month, two-digit year, day of week and a century byte. A prescaler counts oscillator pulses and emits one tick per second. A three-bit trim code stretches or shrinks one second in every averaging window, so the average rate can be pulled by a few tens of ppm.

The host side has a byte port built for a serial bus front end. A read-start event copies all eight time bytes into a snapshot latch, and every byte read afterwards comes from that latch while the live counters keep running. A write-start event copies the live time into a shadow buffer. Each host byte write replaces only its own position in that buffer. A stop event then loads the buffer into the counters and restarts the prescaler, so the new time advances one full second later. An abort event throws the buffer away.

After reset, which stands for power-up from total power loss, a fail flag is raised and the clock stays halted. The first committed write clears the flag and starts the clock.

Top module: `bcd_rtc_top`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD. Each rolls to 00 and carries into the next field.
- R2: When hour bit 7 is 1, the hour field (bits 5:0) counts 00 to 23, and 23 rolls to 00 with a carry into the date.
- R3: When hour bit 7 is 0, bits 4:0 hold 1 to 12 in BCD and bit 5 is the PM flag (1 = PM). Hour 11 goes to 12 and toggles PM, and 12 goes to 1. The date advances only on the PM 11 to AM 12 step.
- R4: The date wraps to 01 after the last day of the month (30 for months 04, 06, 09 and 11, 31 for the others, February per R5). Month counts 01 to 12. Year counts 00 to 99, and the 99 to 00 step moves the century byte from 19 to 20.
- R5: February has 29 days when the year is a multiple of 4, except year 00 with century 19. Otherwise it has 28.
- R6: The day of week (address 6) counts 0 to 6, wraps to 0, and advances whenever the date advances.
- R7: After reset the fail flag is 1, no second tick is produced, and the time stays at sec 00, min 00, hour 00 (12-hour, PM clear), date 01, month 01, year 00, day 0, century 20.
- R8: A read-start pulse copies all eight bytes into the snapshot. host_rdata shows snapshot byte host_addr and does not change as the clock advances.
- R9: A write-start pulse copies the live time into the shadow buffer, and each host_wr replaces only byte host_addr. On a stop after at least one byte, the buffer becomes the live time at once, the prescaler restarts, and the first tick follows CNT_PER_SEC oscillator pulses later.
- R10: An abort pulse discards the buffer and leaves the time unchanged. A host_wr outside a write session has no effect.
- R11: The fail flag clears on the first commit. A stop with no byte written neither clears it nor changes the time.
- R12: Trim code bit 2 is the sign (0 = faster, 1 = slower). Bit 1 weighs 1 step and bit 0 weighs 2 steps. The last second of each TRIM_WINDOW-second window is shortened (faster) or lengthened (slower) by steps times TRIM_UNIT pulses. All other seconds last CNT_PER_SEC pulses.
- R13: Byte addresses are 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 century.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up from total loss) |
| osc_pulse | input | 1 | One oscillator count per asserted cycle |
| trim_code | input | 3 | Digital rate trim: sign and magnitude |
| rd_start | input | 1 | Read boundary: take the snapshot |
| wr_start | input | 1 | Write boundary: load the shadow buffer from live time |
| wr_stop | input | 1 | Valid stop: commit the buffer |
| wr_abort | input | 1 | Invalid sequence: discard the buffer |
| host_wr | input | 1 | Write host_wdata into the buffer at host_addr |
| host_addr | input | 3 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Snapshot byte at host_addr |
| sec_tick_o | output | 1 | One-cycle pulse in the cycle before the time advances |
| fail_o | output | 1 | Clock has not run since the last power loss |

## Verification
Directed start times sit just before each kind of rollover: minute, 24-hour midnight with year and century carry, the three 12-hour hour steps, month ends, and February in a leap year, a non-leap year and the century-19 year 00. Each one separates a wrong carry path from a right one. Random valid times in both hour formats, followed by random runs of ticks, are compared byte by byte with a bench model and catch errors in carry order. Tick spacing is measured for five trim codes, which tells sign, weight and window position apart. Writes of single bytes, empty stops, aborts and stray host writes show what a commit may change and what it must not.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int NREG   = 8;
  localparam int ADDR_W = $clog2(NREG);

  localparam int A_SEC  = 0;
  localparam int A_MIN  = 1;
  localparam int A_HOUR = 2;
  localparam int A_DATE = 3;
  localparam int A_MON  = 4;
  localparam int A_YEAR = 5;
  localparam int A_DOW  = 6;
  localparam int A_CENT = 7;

  typedef logic [NREG-1:0][7:0] tvec_t;

  // BCD increment of one byte (no wrap handling; caller bounds it)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of four in BCD: even tens with units 0/4/8, odd tens with 2/6
  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cent);
    logic by4;
    if (yr[4]) by4 = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       by4 = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return by4 && !((yr == 8'h00) && (cent == 8'h19));
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                     return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

  function automatic tvec_t time_default();
    tvec_t t;
    t         = '0;
    t[A_DATE] = 8'h01;
    t[A_MON]  = 8'h01;
    t[A_CENT] = 8'h20;
    return t;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_PER_SEC = 32768,
  parameter int TRIM_WINDOW = 31,
  parameter int TRIM_UNIT   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic       osc_pulse,
  input  logic [2:0] trim_code,
  output logic       tick
);
  localparam int MAX_TERM = CNT_PER_SEC - 1 + 3 * TRIM_UNIT;
  localparam int CW       = $clog2(MAX_TERM + 1);
  localparam int IW       = (TRIM_WINDOW > 1) ? $clog2(TRIM_WINDOW) : 1;
  localparam logic [CW-1:0] BASE_TERM = CW'(CNT_PER_SEC - 1);
  localparam logic [IW-1:0] LAST_IDX  = IW'(TRIM_WINDOW - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [1:0]    steps;
  logic [CW-1:0] mag;
  logic [CW-1:0] term;
  logic          last_sec;

  always_comb begin
    steps    = {1'b0, trim_code[1]} + {trim_code[0], 1'b0};
    mag      = CW'(steps) * CW'(TRIM_UNIT);
    last_sec = (idx_q == LAST_IDX);
    if (!last_sec)         term = BASE_TERM;
    else if (trim_code[2]) term = BASE_TERM + mag;
    else                   term = BASE_TERM - mag;
    tick = run && osc_pulse && (cnt_q >= term);
  end

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (clear) begin
      cnt_d = '0;
      idx_d = '0;
    end else if (run && osc_pulse) begin
      if (tick) begin
        cnt_d = '0;
        idx_d = last_sec ? '0 : idx_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_TERM));

  assert_no_tick_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import bcd_rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  tvec_t load_val,
  output tvec_t cur
);
  tvec_t cur_q, nxt;
  logic  c_min, c_hour, c_day, c_mon, c_year;
  logic  leap;

  assign cur = cur_q;

  always_comb begin
    nxt    = cur_q;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    leap   = is_leap(cur_q[A_YEAR], cur_q[A_CENT]);
    if (load) begin
      nxt = load_val;
    end else if (tick) begin
      // seconds
      if (cur_q[A_SEC] >= 8'h59) begin
        nxt[A_SEC] = 8'h00;
        c_min      = 1'b1;
      end else begin
        nxt[A_SEC] = bcd_inc(cur_q[A_SEC]);
      end
      // minutes
      if (c_min) begin
        if (cur_q[A_MIN] >= 8'h59) begin
          nxt[A_MIN] = 8'h00;
          c_hour     = 1'b1;
        end else begin
          nxt[A_MIN] = bcd_inc(cur_q[A_MIN]);
        end
      end
      // hours, two formats
      if (c_hour) begin
        if (cur_q[A_HOUR][7]) begin
          if (cur_q[A_HOUR][6:0] >= 7'h23) begin
            nxt[A_HOUR] = 8'h80;
            c_day       = 1'b1;
          end else begin
            nxt[A_HOUR] = {2'b10, 6'(bcd_inc({2'b00, cur_q[A_HOUR][5:0]}))};
          end
        end else if (cur_q[A_HOUR][4:0] == 5'h12) begin
          nxt[A_HOUR] = {2'b00, cur_q[A_HOUR][5], 5'h01};
        end else if (cur_q[A_HOUR][4:0] == 5'h11) begin
          nxt[A_HOUR] = {2'b00, ~cur_q[A_HOUR][5], 5'h12};
          c_day       = cur_q[A_HOUR][5];
        end else begin
          nxt[A_HOUR] = {2'b00, cur_q[A_HOUR][5], 5'(bcd_inc({3'b000, cur_q[A_HOUR][4:0]}))};
        end
      end
      // date and day of week
      if (c_day) begin
        nxt[A_DOW] = (cur_q[A_DOW] >= 8'h06) ? 8'h00 : cur_q[A_DOW] + 8'h01;
        if (cur_q[A_DATE] >= last_day(cur_q[A_MON], leap)) begin
          nxt[A_DATE] = 8'h01;
          c_mon       = 1'b1;
        end else begin
          nxt[A_DATE] = bcd_inc(cur_q[A_DATE]);
        end
      end
      // month
      if (c_mon) begin
        if (cur_q[A_MON] >= 8'h12) begin
          nxt[A_MON] = 8'h01;
          c_year     = 1'b1;
        end else begin
          nxt[A_MON] = bcd_inc(cur_q[A_MON]);
        end
      end
      // year and century
      if (c_year) begin
        if (cur_q[A_YEAR] >= 8'h99) begin
          nxt[A_YEAR] = 8'h00;
          if (cur_q[A_CENT] == 8'h19) nxt[A_CENT] = 8'h20;
        end else begin
          nxt[A_YEAR] = bcd_inc(cur_q[A_YEAR]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= time_default();
    else        cur_q <= nxt;
  end

  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur_q[A_SEC] == 8'h59) |=> (cur_q[A_SEC] == 8'h00));

  assert_hour24_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur_q[A_SEC] == 8'h59 && cur_q[A_MIN] == 8'h59 &&
     cur_q[A_HOUR] == 8'hA3) |=> (cur_q[A_HOUR] == 8'h80));

  assert_time_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur_q));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(load_val)));

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              wr_start,
  input  logic              wr_stop,
  input  logic              wr_abort,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  tvec_t             live,
  output logic [7:0]        host_rdata,
  output logic              commit,
  output tvec_t             commit_val
);
  tvec_t snap_q, snap_d;
  tvec_t shadow_q, shadow_d;
  logic  open_q, open_d;
  logic  dirty_q, dirty_d;
  logic  byte_wr;

  assign byte_wr    = host_wr && open_q && !wr_start;
  assign host_rdata = snap_q[host_addr];
  assign commit     = wr_stop && open_q && dirty_q;
  assign commit_val = shadow_q;

  always_comb begin
    snap_d   = rd_start ? live : snap_q;
    shadow_d = shadow_q;
    open_d   = open_q;
    dirty_d  = dirty_q;
    if (wr_start) begin
      shadow_d = live;
      open_d   = 1'b1;
      dirty_d  = 1'b0;
    end else begin
      if (byte_wr) begin
        shadow_d[host_addr] = host_wdata;
        dirty_d             = 1'b1;
      end
      if (wr_stop || wr_abort) begin
        open_d  = 1'b0;
        dirty_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= time_default();
      shadow_q <= time_default();
      open_q   <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      snap_q   <= snap_d;
      shadow_q <= shadow_d;
      open_q   <= open_d;
      dirty_q  <= dirty_d;
    end
  end

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(snap_q));

  assert_abort_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_abort && !wr_start) |=> (!open_q && !commit));

  assert_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !wr_start) |=> $stable(shadow_q));

endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
  import bcd_rtc_pkg::*;
#(
  parameter int CNT_PER_SEC = 32768,
  parameter int TRIM_WINDOW = 31,
  parameter int TRIM_UNIT   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_pulse,
  input  logic [2:0] trim_code,
  input  logic       rd_start,
  input  logic       wr_start,
  input  logic       wr_stop,
  input  logic       wr_abort,
  input  logic       host_wr,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       sec_tick_o,
  output logic       fail_o
);
  logic  rst_s0_q, rst_s1_q, rst_core_n;
  logic  fail_q, fail_d;
  logic  commit;
  tvec_t commit_val;
  tvec_t live;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_core_n = rst_s1_q;

  always_comb fail_d = commit ? 1'b0 : fail_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) fail_q <= 1'b1;
    else             fail_q <= fail_d;
  end
  assign fail_o = fail_q;

  rtc_prescaler #(
    .CNT_PER_SEC (CNT_PER_SEC),
    .TRIM_WINDOW (TRIM_WINDOW),
    .TRIM_UNIT   (TRIM_UNIT)
  ) u_presc (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (!fail_q),
    .clear     (commit),
    .osc_pulse (osc_pulse),
    .trim_code (trim_code),
    .tick      (sec_tick_o)
  );

  rtc_time_counter u_time (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (sec_tick_o),
    .load     (commit),
    .load_val (commit_val),
    .cur      (live)
  );

  rtc_host_port u_host (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rd_start   (rd_start),
    .wr_start   (wr_start),
    .wr_stop    (wr_stop),
    .wr_abort   (wr_abort),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .live       (live),
    .host_rdata (host_rdata),
    .commit     (commit),
    .commit_val (commit_val)
  );

  assert_fail_clear_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    commit |=> !fail_q);

  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fail_q && !commit) |=> fail_q);

  assert_halted_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    fail_q |-> !sec_tick_o);

endmodule

// File: tb/bcd_rtc_top_tb_top.sv
module bcd_rtc_top_tb_top;
  import bcd_rtc_pkg::*;

  localparam int DIV  = 8;
  localparam int WIN  = 4;
  localparam int UNIT = 1;

  logic       clk;
  logic       rst_n;
  logic       osc_pulse;
  logic [2:0] trim_code;
  logic       rd_start, wr_start, wr_stop, wr_abort, host_wr;
  logic [2:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       sec_tick_o;
  logic       fail_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_count = 0;
  int tstamp [64];
  int applied = 0;
  tvec_t exp_t;
  bit done = 0;

  bcd_rtc_top #(.CNT_PER_SEC(DIV), .TRIM_WINDOW(WIN), .TRIM_UNIT(UNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .trim_code(trim_code),
    .rd_start(rd_start), .wr_start(wr_start), .wr_stop(wr_stop), .wr_abort(wr_abort),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .sec_tick_o(sec_tick_o), .fail_o(fail_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sec_tick_o) begin
      tstamp[tick_count % 64] = cyc;
      tick_count = tick_count + 1;
    end
  end

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int mo, input int y, input int c);
    bit lp;
    lp = (y % 4 == 0) && !(y == 0 && c == 19);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // independent model of one second step
  function automatic tvec_t bnext(input tvec_t t);
    int s, m, h, d, mo, y, c, w;
    bit h24, pm, dayadv;
    logic [7:0] hb;
    tvec_t r;
    s = b2i(t[0]); m = b2i(t[1]); d = b2i(t[3]); mo = b2i(t[4]);
    y = b2i(t[5]); w = int'(t[6]); c = b2i(t[7]);
    h24 = t[2][7]; pm = t[2][5];
    h = h24 ? b2i({2'b00, t[2][5:0]}) : b2i({3'b000, t[2][4:0]});
    dayadv = 0;
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0;
        if (h24) begin
          h++;
          if (h == 24) begin h = 0; dayadv = 1; end
        end else if (h == 12) h = 1;
        else if (h == 11) begin h = 12; dayadv = pm; pm = !pm; end
        else h++;
      end
    end
    if (dayadv) begin
      w = (w + 1) % 7;
      d++;
      if (d > mdays(mo, y, c)) begin
        d = 1; mo++;
        if (mo > 12) begin
          mo = 1; y++;
          if (y > 99) begin y = 0; if (c == 19) c = 20; end
        end
      end
    end
    hb = i2b(h);
    r = t;
    r[0] = i2b(s); r[1] = i2b(m); r[3] = i2b(d); r[4] = i2b(mo);
    r[5] = i2b(y); r[6] = 8'(w); r[7] = i2b(c);
    r[2] = h24 ? {2'b10, hb[5:0]} : {2'b00, pm, hb[4:0]};
    return r;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic checki(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // bring model up to the live value seen by a capture at the coming edge
  task automatic sync_model();
    int target;
    target = tick_count - (sec_tick_o ? 1 : 0);
    while (applied < target) begin
      exp_t = bnext(exp_t);
      applied++;
    end
  endtask

  task automatic read_all(output tvec_t got, output tvec_t want);
    @(negedge clk); #1;
    sync_model();
    want = exp_t;
    rd_start = 1'b1;
    @(negedge clk); #1;
    rd_start = 1'b0;
    for (int a = 0; a < NREG; a++) begin
      host_addr = 3'(a);
      #1;
      got[a] = host_rdata;
    end
  endtask

  task automatic compare_all(input string req);
    tvec_t got, want;
    read_all(got, want);
    for (int a = 0; a < NREG; a++) check8(req, got[a], want[a]);
  endtask

  // mode: 0 = stop, 1 = abort
  task automatic write_regs(input tvec_t val, input logic [7:0] mask, input int mode,
                            output int stop_cyc);
    tvec_t shadow;
    @(negedge clk); #1;
    sync_model();
    shadow = exp_t;
    wr_start = 1'b1;
    @(negedge clk); #1;
    wr_start = 1'b0;
    for (int a = 0; a < NREG; a++) begin
      if (mask[a]) begin
        host_wr = 1'b1; host_addr = 3'(a); host_wdata = val[a];
        shadow[a] = val[a];
        @(negedge clk); #1;
        host_wr = 1'b0;
      end
    end
    sync_model();
    stop_cyc = cyc;
    if (mode == 0) wr_stop = 1'b1; else wr_abort = 1'b1;
    if (mode == 0 && mask != 8'h00 && !(fail_o && 0)) begin
      exp_t = shadow;
      applied = tick_count;
    end
    @(negedge clk); #1;
    wr_stop = 1'b0; wr_abort = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = tick_count + n;
    while (tick_count < target) @(negedge clk);
  endtask

  function automatic tvec_t mk(input logic [7:0] c, input logic [7:0] w, input logic [7:0] y,
                               input logic [7:0] mo, input logic [7:0] d, input logic [7:0] h,
                               input logic [7:0] mi, input logic [7:0] s);
    tvec_t t;
    t[7] = c; t[6] = w; t[5] = y; t[4] = mo; t[3] = d; t[2] = h; t[1] = mi; t[0] = s;
    return t;
  endfunction

  task automatic set_and_step(input tvec_t t, input int n, input string req,
                              input int addr, input logic [7:0] expv);
    tvec_t got, want;
    int sc;
    write_regs(t, 8'hFF, 0, sc);
    wait_ticks(n);
    read_all(got, want);
    for (int a = 0; a < NREG; a++) check8(req, got[a], want[a]);
    check8(req, got[addr], expv);
  endtask

  task automatic trim_case(input logic [2:0] code, input int expv);
    int sc, base;
    trim_code = code;
    write_regs(mk(8'h20, 8'h01, 8'h10, 8'h03, 8'h03, 8'h81, 8'h00, 8'h00), 8'h01, 0, sc);
    base = tick_count;
    wait_ticks(5);
    checki("R12 first second", tstamp[base % 64] - sc, DIV);
    checki("R12 normal second", tstamp[(base + 2) % 64] - tstamp[(base + 1) % 64], DIV);
    checki("R12 trimmed second", tstamp[(base + 3) % 64] - tstamp[(base + 2) % 64], expv);
    checki("R12 after window", tstamp[(base + 4) % 64] - tstamp[(base + 3) % 64], DIV);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tvec_t got, want, t;
    int sc, t0;
    void'($urandom(32'd1205));
    rst_n = 1'b0; osc_pulse = 1'b1; trim_code = 3'b000;
    rd_start = 0; wr_start = 0; wr_stop = 0; wr_abort = 0; host_wr = 0;
    host_addr = 0; host_wdata = 0;
    exp_t = time_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 and R13: defaults at their addresses, halted, fail set
    t0 = tick_count;
    repeat (60) @(negedge clk);
    checki("R7 no ticks while failed", tick_count - t0, 0);
    checki("R7 fail flag after reset", int'(fail_o), 1);
    compare_all("R7 reset values");
    read_all(got, want);
    check8("R13 century at address 7", got[7], 8'h20);
    check8("R13 month at address 4", got[4], 8'h01);

    // R10: stray write outside a session
    @(negedge clk); #1;
    host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'h33;
    @(negedge clk); #1;
    host_wr = 1'b0;
    write_regs(time_default(), 8'h00, 0, sc);
    read_all(got, want);
    check8("R10 stray write ignored", got[0], 8'h00);
    // R11: empty stop leaves flag set
    checki("R11 empty stop keeps fail", int'(fail_o), 1);

    // R10: abort discards
    write_regs(mk(8'h19, 8'h03, 8'h55, 8'h07, 8'h17, 8'h85, 8'h44, 8'h22), 8'hFF, 1, sc);
    checki("R10 abort keeps fail", int'(fail_o), 1);
    compare_all("R10 abort discards");

    // R9 and R11: one byte commit
    t = time_default();
    t[A_MIN] = 8'h45;
    write_regs(t, 8'h02, 0, sc);
    t0 = tick_count;
    checki("R11 first commit clears fail", int'(fail_o), 0);
    read_all(got, want);
    check8("R9 written byte", got[A_MIN], 8'h45);
    check8("R9 untouched byte", got[A_DATE], 8'h01);
    compare_all("R9 single byte");
    wait_ticks(1);
    if (tick_count - t0 >= 1)
      checki("R9 first tick after commit", tstamp[t0 % 64] - sc, DIV);

    // R1 minute carry
    set_and_step(mk(8'h20, 8'h02, 8'h21, 8'h06, 8'h15, 8'h87, 8'h59, 8'h58), 2,
                 "R1 minute and hour carry", A_HOUR, 8'h88);
    // R2 R4 R6 midnight, year and century rollover
    set_and_step(mk(8'h19, 8'h06, 8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59), 1,
                 "R4 century rollover", A_CENT, 8'h20);
    set_and_step(mk(8'h19, 8'h06, 8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59), 1,
                 "R6 day of week wraps", A_DOW, 8'h00);
    set_and_step(mk(8'h20, 8'h02, 8'h30, 8'h04, 8'h30, 8'hA3, 8'h59, 8'h59), 1,
                 "R2 midnight hour", A_HOUR, 8'h80);
    set_and_step(mk(8'h20, 8'h02, 8'h30, 8'h04, 8'h30, 8'hA3, 8'h59, 8'h59), 1,
                 "R4 thirty day month", A_MON, 8'h05);
    // R3 twelve hour steps
    set_and_step(mk(8'h20, 8'h01, 8'h22, 8'h05, 8'h10, 8'h31, 8'h59, 8'h59), 1,
                 "R3 PM 11 to AM 12", A_HOUR, 8'h12);
    set_and_step(mk(8'h20, 8'h01, 8'h22, 8'h05, 8'h10, 8'h31, 8'h59, 8'h59), 1,
                 "R3 date advances at midnight", A_DATE, 8'h11);
    set_and_step(mk(8'h20, 8'h01, 8'h22, 8'h05, 8'h10, 8'h11, 8'h59, 8'h59), 1,
                 "R3 AM 11 to PM 12", A_HOUR, 8'h32);
    set_and_step(mk(8'h20, 8'h01, 8'h22, 8'h05, 8'h10, 8'h11, 8'h59, 8'h59), 1,
                 "R3 noon keeps date", A_DATE, 8'h10);
    set_and_step(mk(8'h20, 8'h01, 8'h22, 8'h05, 8'h10, 8'h32, 8'h59, 8'h59), 1,
                 "R3 12 to 1", A_HOUR, 8'h21);
    // R5 leap years
    set_and_step(mk(8'h20, 8'h03, 8'h24, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59), 1,
                 "R5 leap 2024", A_DATE, 8'h29);
    set_and_step(mk(8'h20, 8'h03, 8'h23, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59), 1,
                 "R5 non leap 2023", A_MON, 8'h03);
    set_and_step(mk(8'h19, 8'h03, 8'h00, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59), 1,
                 "R5 century 19 year 00", A_MON, 8'h03);
    set_and_step(mk(8'h20, 8'h03, 8'h00, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59), 1,
                 "R5 century 20 year 00", A_DATE, 8'h29);
    set_and_step(mk(8'h20, 8'h03, 8'h96, 8'h02, 8'h29, 8'hA3, 8'h59, 8'h59), 1,
                 "R5 end of leap February", A_MON, 8'h03);

    // R8 snapshot stays put while time runs
    read_all(got, want);
    wait_ticks(3);
    host_addr = 3'(A_SEC);
    #1;
    check8("R8 snapshot stable", host_rdata, want[A_SEC]);
    compare_all("R8 fresh snapshot");

    // random valid times, random durations
    for (int i = 0; i < 20; i++) begin
      bit h24;
      int hh;
      h24 = $urandom_range(0, 1) != 0;
      hh  = h24 ? $urandom_range(0, 23) : $urandom_range(1, 12);
      t = mk($urandom_range(0, 1) != 0 ? 8'h20 : 8'h19, 8'($urandom_range(0, 6)),
             i2b($urandom_range(0, 99)), i2b($urandom_range(1, 12)),
             i2b($urandom_range(25, 28)), 8'h00, i2b($urandom_range(57, 59)),
             i2b($urandom_range(40, 59)));
      t[A_HOUR] = h24 ? {2'b10, 6'(i2b(hh))} : {2'b00, 1'($urandom_range(0, 1)), 5'(i2b(hh))};
      write_regs(t, 8'hFF, 0, sc);
      wait_ticks($urandom_range(1, 70));
      compare_all(h24 ? "R1 R2 R4 random 24h" : "R1 R3 R4 random 12h");
    end

    // R12 trim codes
    trim_case(3'b000, DIV);
    trim_case(3'b010, DIV - UNIT);
    trim_case(3'b011, DIV - 3 * UNIT);
    trim_case(3'b101, DIV + 2 * UNIT);
    trim_case(3'b100, DIV);
    trim_code = 3'b000;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule